// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Up-Counter

This block is a binary up-counter whose state register updates only on the rising clock edge. It offers an active-low synchronous clear, an active-low synchronous parallel preset from a data bus, and two active-high count enables with separate roles. Counting advances only when both enables are high. The second enable, the chain enable, also gates a combinational carry output that is high while the count sits at its all-ones value.

Several instances chain into one wider synchronous counter with no extra logic. All stages share the clock and tie their free-running enable high. The carry of each stage drives the chain enable of the next, more significant stage. A shorter cycle length comes from decoding the chosen final count with an active-low gate and feeding that decode back into the clear input. The width is a parameter and defaults to 4 bits.

Top module: `sync_preset_counter`

## Requirements
- R1: The count register changes only at a rising edge of `clk`, and all of its bits change at that same edge.
- R2: When `sclr_n` is 0 at a rising edge, `cnt` becomes 0 at that edge. This overrides `ld_n`, `cnt_en` and `chain_en`.
- R3: When `ld_n` is 0 and `sclr_n` is 1 at a rising edge, `cnt` takes the value of `din` at that edge, whatever the enables are.
- R4: When `sclr_n`, `ld_n`, `cnt_en` and `chain_en` are all 1 at a rising edge, `cnt` increments by one.
- R5: When `sclr_n` and `ld_n` are 1 and either `cnt_en` or `chain_en` is 0 at a rising edge, `cnt` keeps its value.
- R6: `carry_out` is 1 exactly when `cnt` is all ones (15 at the default width) and `chain_en` is 1. `cnt_en` has no effect on it.
- R7: The count runs in plain binary order and wraps from all ones to 0.
- R8: Toggling `cnt_en`, `chain_en`, `ld_n` or `din` between edges leaves `cnt` unchanged. Only the levels present at the edge decide the operation.
- R9: Two 4-bit stages, with the low stage's `carry_out` driving the high stage's `chain_en` and both `cnt_en` tied to 1, form an 8-bit counter. It steps through 0 to 255 with no value skipped or repeated and then wraps.
- R10: When `sclr_n` is driven by an active-low decode of count 9, the counter cycles 0 through 9. It returns to 0 at the edge after 9 appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| sclr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable, active high; does not affect the carry |
| chain_en | input | 1 | Count enable, active high; also gates `carry_out` |
| din | input | WIDTH | Preset value |
| cnt | output | WIDTH | Current count |
| carry_out | output | 1 | High while the count is all ones and `chain_en` is high |

## Verification
The embedded assertions check the per-edge operation on every cycle once the first clear has been seen: clear to zero, preset from `din`, increment, hold when an enable is low, and a carry only at full count. Behaviour that depends on the timing of stimulus or on how instances are connected is shown only by the bench scenarios. That covers inputs toggled between edges having no effect, the 256-state cascade sequence, the mod-10 cycle set up by clear feedback, and the documented sequence of clear, preset to 12, count through the wrap, then inhibit. The bench also sweeps every start value against every control combination.

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             sclr_n,
  input  logic             ld_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_r;
  logic             run;

  assign run = cnt_en & chain_en;

  always_ff @(posedge clk) begin
    if (!sclr_n)   cnt_r <= '0;
    else if (!ld_n) cnt_r <= din;
    else if (run)   cnt_r <= cnt_r + 1'b1;
  end

  assign cnt       = cnt_r;
  assign carry_out = chain_en & (cnt_r == FULL);

  // assertion qualifier: state is known once a clear has been taken
  logic chk_live = 1'b0;
  always_ff @(posedge clk) chk_live <= chk_live | ~sclr_n;

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!chk_live)
    !sclr_n |=> (cnt == '0));

  a_r3_preset: assert property (@(posedge clk) disable iff (!chk_live)
    (sclr_n && !ld_n) |=> (cnt == $past(din)));

  a_r4_r7_step: assert property (@(posedge clk) disable iff (!chk_live)
    (sclr_n && ld_n && cnt_en && chain_en) |=> (cnt == WIDTH'($past(cnt) + 1'b1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!chk_live)
    (sclr_n && ld_n && !(cnt_en && chain_en)) |=> $stable(cnt));

  a_r6_carry_at_full: assert property (@(posedge clk) disable iff (!chk_live)
    carry_out |-> (chain_en && cnt == FULL));
endmodule

// File: tb/sync_preset_counter_tb.sv
module sync_preset_counter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // main instance
  logic       sclr_n = 1'b1, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt;
  logic       carry_out;

  sync_preset_counter #(.WIDTH(4)) u_dut (
    .clk(clk), .sclr_n(sclr_n), .ld_n(ld_n), .cnt_en(cnt_en), .chain_en(chain_en),
    .din(din), .cnt(cnt), .carry_out(carry_out));

  // two-stage cascade
  logic       cas_clr_n = 1'b1;
  logic [3:0] lo_q, hi_q;
  logic       lo_c, hi_c;

  sync_preset_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .sclr_n(cas_clr_n), .ld_n(1'b1), .cnt_en(1'b1), .chain_en(1'b1),
    .din(4'd0), .cnt(lo_q), .carry_out(lo_c));
  sync_preset_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .sclr_n(cas_clr_n), .ld_n(1'b1), .cnt_en(1'b1), .chain_en(lo_c),
    .din(4'd0), .cnt(hi_q), .carry_out(hi_c));

  // truncated modulus by clear feedback (decode of 9)
  logic       mod_init_n = 1'b1;
  logic [3:0] m_q;
  logic       m_c;
  logic       m_clr_n;
  assign m_clr_n = mod_init_n & ~(m_q == 4'd9);

  sync_preset_counter #(.WIDTH(4)) u_mod (
    .clk(clk), .sclr_n(m_clr_n), .ld_n(1'b1), .cnt_en(1'b1), .chain_en(1'b1),
    .din(4'd0), .cnt(m_q), .carry_out(m_c));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change at negedge; one edge then back to the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R2: clear at first edge, with everything else active
    sclr_n = 1'b0; ld_n = 1'b0; din = 4'd7; cnt_en = 1'b1; chain_en = 1'b1;
    cas_clr_n = 1'b0; mod_init_n = 1'b0;
    tick();
    chk(cnt == 4'd0, "R2 clear over load/count", cnt, 0);
    cas_clr_n = 1'b1; mod_init_n = 1'b1;

    // directed: preset 12, count 13,14,15,0,1,2, then inhibit
    sclr_n = 1'b1; ld_n = 1'b0; din = 4'd12; cnt_en = 1'b1; chain_en = 1'b1;
    tick();
    chk(cnt == 4'd12, "R3 preset 12", cnt, 12);
    ld_n = 1'b1; din = 4'd0;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(cnt == 4'((12 + k) % 16), "R4 R7 directed count", cnt, (12 + k) % 16);
      if (cnt == 4'd15) chk(carry_out == 1'b1, "R6 carry at 15", carry_out, 1);
    end
    cnt_en = 1'b0;
    tick();
    chk(cnt == 4'd2, "R5 inhibit by cnt_en", cnt, 2);
    cnt_en = 1'b1; chain_en = 1'b0;
    tick();
    chk(cnt == 4'd2, "R5 inhibit by chain_en", cnt, 2);

    // exhaustive sweep: every start value x every control combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        sclr_n = 1'b1; ld_n = 1'b0; din = 4'(s); cnt_en = 1'b0; chain_en = 1'b0;
        tick();
        sclr_n = c[3]; ld_n = c[2]; cnt_en = c[1]; chain_en = c[0];
        din = 4'(~s);
        #2;
        chk(carry_out == ((s == 15) && c[0]), "R6 carry decode", carry_out,
            ((s == 15) && c[0]) ? 1 : 0);
        begin
          int e;
          if (!c[3]) e = 0;
          else if (!c[2]) e = (~s) & 15;
          else if (c[1] && c[0]) e = (s + 1) % 16;
          else e = s;
          tick();
          chk(cnt == 4'(e), "R2 R3 R4 R5 sweep", cnt, e);
        end
      end
    end

    // R1 R8: toggle inputs between edges, no change until the edge
    sclr_n = 1'b1; ld_n = 1'b0; din = 4'd5; cnt_en = 1'b0; chain_en = 1'b0;
    tick();
    ld_n = 1'b1;
    for (int t = 0; t < 4; t++) begin
      #2 cnt_en = ~cnt_en; chain_en = ~chain_en; ld_n = ~ld_n; din = din + 4'd3;
    end
    #1;
    chk(cnt == 4'd5, "R1 R8 no change between edges", cnt, 5);
    cnt_en = 1'b0; chain_en = 1'b1; ld_n = 1'b1;
    tick();
    chk(cnt == 4'd5, "R8 only edge levels count", cnt, 5);
    cnt_en = 1'b1;
    tick();
    chk(cnt == 4'd6, "R1 steps at edge", cnt, 6);
    cnt_en = 1'b0;

    // R9: cascade, restart from 0
    cas_clr_n = 1'b0;
    tick();
    cas_clr_n = 1'b1;
    chk({hi_q, lo_q} == 8'd0, "R9 cascade cleared", {hi_q, lo_q}, 0);
    for (int k = 1; k <= 260; k++) begin
      tick();
      chk({hi_q, lo_q} == 8'(k % 256), "R9 cascade sequence", {hi_q, lo_q}, k % 256);
    end

    // R10: truncated modulus, restart from 0
    mod_init_n = 1'b0;
    tick();
    mod_init_n = 1'b1;
    chk(m_q == 4'd0, "R10 mod start", m_q, 0);
    for (int k = 1; k <= 30; k++) begin
      tick();
      chk(m_q == 4'(k % 10), "R10 mod-10 cycle", m_q, k % 10);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule